// File: doc/BRIEF.md
# Iterative Top-K Selector Tree

This block picks the five largest entries out of a frame of 64 unsigned 16-bit magnitudes, and reports each one's value and position. A caller presents all 64 values in parallel on one wide bus and raises `start` for one clock. The block copies the frame and then runs a six-level pairwise comparison tree five times. After each run it removes the winner from the field, so the next run finds the next-largest entry.

One run through the tree takes six clocks, one per level, so the five runs use 30 clocks. This fits inside a frame period of 32 clocks. The ranked slots fill in one at a time, largest first. A one-clock `done` pulse marks the moment the fifth slot is valid. Each tree node carries its candidate's index beside its value. When two values are equal, the lower index ranks ahead.

Top module: `topk_select_tree`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and every ranked value and index output is 0.
- R2: `done` is high for exactly one clock per accepted frame. It becomes visible 30 clocks after the clock edge that samples the accepted `start`.
- R3: When `done` is high, slot 0 (the lowest `W` bits of `top_val` and the lowest 6 bits of `top_idx`) holds the largest loaded value. Slots 1 to 4 hold values in non-increasing order.
- R4: Every reported index points to a loaded entry whose value equals the reported value, and the five indices are distinct. This holds even when every value is zero, because a removed entry always ranks below any remaining entry.
- R5: Among equal values, the entry with the lower index takes the earlier slot.
- R6: A `start` sampled while a search is running, including on the clock edge that raises `done`, has no effect. The frame data, the results, the `done` timing and the number of `done` pulses are unchanged.
- R7: A new frame is accepted on the first clock edge after the one that raises `done`. Frames started every 32 clocks all complete.
- R8: After `done`, the outputs hold their values until a later accepted frame overwrites them.
- R9: Slot k (k = 0..4) is written on the edge 6(k+1) clocks after the accepting edge. Slots not yet reached keep their previous values.

Reset `rst_n` is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame load strobe, honoured only while idle |
| cand_in | input | N*W (1024) | 64 candidate magnitudes; entry i sits at bits i*W upward |
| top_val | output | K*W (80) | Ranked values; slot k sits at bits k*W upward, slot 0 is the largest |
| top_idx | output | K*6 (30) | Ranked indices; slot k sits at bits k*6 upward |
| done | output | 1 | One-clock pulse when all five slots are valid |

## Verification
The assertions assume the block is configured with fewer slots than candidates. Under that condition, every pass meets at least one entry that has not been removed, so ordering, tie-break and distinctness can be checked purely at the outputs whenever `done` is high.

They also assume that `start` arrives no sooner than one clock after `done`. This is what keeps the outputs steady in the cycle after the pulse. The stimulus respects this for every accepted frame. Strobes that deliberately fall inside a running search are never predicted as accepted, so the scoreboard expects them to leave no trace.

// File: rtl/topk_select_tree.sv
module topk_select_tree #(
  parameter int N = 64,
  parameter int W = 16,
  parameter int K = 5,
  localparam int IDXW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*W-1:0]    cand_in,
  output logic [K*W-1:0]    top_val,
  output logic [K*IDXW-1:0] top_idx,
  output logic              done
);

  localparam int LEVELS = IDXW;
  localparam int NW     = 1 + W + IDXW;
  localparam int NODES  = N - 2;
  localparam int STEPW  = $clog2(LEVELS);
  localparam int PASSW  = (K > 1) ? $clog2(K) : 1;
  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(LEVELS - 1);
  localparam logic [PASSW-1:0] LAST_PASS = PASSW'(K - 1);

  function automatic int base(input int l);
    return N - 2 * (N >> l);
  endfunction

  function automatic logic [NW-1:0] pick(input logic [NW-1:0] a, input logic [NW-1:0] b);
    if (a[NW-1] != b[NW-1]) return a[NW-1] ? a : b;
    return (a[NW-2 -: W] >= b[NW-2 -: W]) ? a : b;
  endfunction

  logic [W-1:0]    cand_q [N];
  logic [N-1:0]    mask_q;
  logic [NW-1:0]   leaf   [N];
  logic [NW-1:0]   node_d [NODES];
  logic [NW-1:0]   node_q [NODES];
  logic [NW-1:0]   win;
  logic            busy_q, done_q;
  logic [STEPW-1:0] step_q;
  logic [PASSW-1:0] pass_q;
  logic [W-1:0]    val_q [K];
  logic [IDXW-1:0] idx_q [K];

  wire accept  = start & ~busy_q;
  wire at_last = busy_q & (step_q == LAST_STEP);
  wire wr      = at_last & win[NW-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign leaf[i] = {~mask_q[i], cand_q[i], IDXW'(i)};
  end

  for (genvar l = 1; l < LEVELS; l++) begin : g_lvl
    for (genvar j = 0; j < (N >> l); j++) begin : g_node
      if (l == 1) begin : g_first
        assign node_d[j] = pick(leaf[2*j], leaf[2*j+1]);
      end else begin : g_inner
        assign node_d[base(l)+j] = pick(node_q[base(l-1)+2*j], node_q[base(l-1)+2*j+1]);
      end
    end
  end

  assign win = pick(node_q[NODES-2], node_q[NODES-1]);

  always_ff @(posedge clk) node_q <= node_d;

  always_ff @(posedge clk)
    if (accept)
      for (int i = 0; i < N; i++) cand_q[i] <= cand_in[i*W +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      pass_q <= '0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        pass_q <= '0;
        mask_q <= '0;
      end else if (busy_q) begin
        if (step_q == LAST_STEP) begin
          step_q <= '0;
          if (win[NW-1]) mask_q[win[IDXW-1:0]] <= 1'b1;
          if (pass_q == LAST_PASS) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            pass_q <= pass_q + 1'b1;
          end
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < K; k++) begin
        val_q[k] <= '0;
        idx_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < K; k++)
        if (wr && pass_q == PASSW'(k)) begin
          val_q[k] <= win[IDXW +: W];
          idx_q[k] <= win[IDXW-1:0];
        end
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_out
    assign top_val[k*W +: W]       = val_q[k];
    assign top_idx[k*IDXW +: IDXW] = idx_q[k];
  end

  assign done = done_q;

endmodule

// File: rtl/topk_select_chk.sv
module topk_select_chk #(
  parameter int K    = 5,
  parameter int W    = 16,
  parameter int IDXW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [K*W-1:0]    top_val,
  input logic [K*IDXW-1:0] top_idx
);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(top_val) && $stable(top_idx)));

  for (genvar k = 0; k < K - 1; k++) begin : g_pair
    // R3
    rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> top_val[k*W +: W] >= top_val[(k+1)*W +: W]);
    // R5
    tie_low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && top_val[k*W +: W] == top_val[(k+1)*W +: W])
        |-> top_idx[k*IDXW +: IDXW] < top_idx[(k+1)*IDXW +: IDXW]);
  end

  for (genvar a = 0; a < K; a++) begin : g_da
    for (genvar b = a + 1; b < K; b++) begin : g_db
      // R4
      distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> top_idx[a*IDXW +: IDXW] != top_idx[b*IDXW +: IDXW]);
    end
  end

endmodule

bind topk_select_tree topk_select_chk #(.K(K), .W(W), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .top_val(top_val), .top_idx(top_idx)
);

// File: tb/test_topk_select_tree.sv
module test_topk_select_tree;
  localparam int N = 64, W = 16, K = 5, IW = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N*W-1:0]  cand_in = '0;
  logic [K*W-1:0]  top_val;
  logic [K*IW-1:0] top_idx;
  logic            done;

  topk_select_tree i_topk_select_tree (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_in(cand_in),
    .top_val(top_val), .top_idx(top_idx), .done(done)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int q_val[$], q_idx[$], q_done[$];
  int last_val[K], last_idx[K];
  int stim[N];
  bit prev_done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit accept);
    bit used[N];
    for (int i = 0; i < N; i++) begin
      cand_in[i*W +: W] = W'(stim[i]);
      used[i] = 1'b0;
    end
    start = 1'b1;
    if (accept) begin
      for (int k = 0; k < K; k++) begin
        int best = -1;
        for (int i = 0; i < N; i++)
          if (!used[i] && (best < 0 || stim[i] > stim[best])) best = i;
        used[best] = 1'b1;
        q_val.push_back(stim[best]);
        q_idx.push_back(best);
      end
      q_done.push_back(cyc + 31);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (q_done.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rand_stim(input int lim);
    for (int i = 0; i < N; i++) stim[i] = int'($urandom % lim);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) check(1'b0, "R2 done longer than one clock", 1, 0);
      if (done) begin
        if (q_done.size() == 0) begin
          check(1'b0, "R6 done without an accepted frame", 1, 0);
        end else begin
          int e;
          e = q_done.pop_front();
          check(cyc == e, "R2 done timing", cyc, e);
          for (int k = 0; k < K; k++) begin
            int ev, ei;
            ev = q_val.pop_front();
            ei = q_idx.pop_front();
            check(int'(top_val[k*W +: W]) == ev, "R3 ranked value", top_val[k*W +: W], ev);
            check(int'(top_idx[k*IW +: IW]) == ei, "R4/R5 ranked index", top_idx[k*IW +: IW], ei);
            last_val[k] = ev;
            last_idx[k] = ei;
          end
        end
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(top_val == '0, "R1 values in reset", top_val, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(top_idx == '0 && top_val == '0 && !done, "R1 after release", top_idx, 0);

    // R3 random distinct-ish frame
    rand_stim(65535);
    drive(1'b1);
    wait_done();

    // R9 slot timing: slot0 at +6, slot1 still old, slot1 at +12
    for (int i = 0; i < N; i++) stim[i] = i;
    stim[20] = 65535;
    drive(1'b1);
    repeat (6) @(negedge clk);
    check(top_val[0 +: W] == 16'hFFFF, "R9 slot0 value after six clocks", top_val[0 +: W], 65535);
    check(top_idx[0 +: IW] == 6'd20, "R9 slot0 index after six clocks", top_idx[0 +: IW], 20);
    check(int'(top_val[W +: W]) == last_val[1], "R9 slot1 still old", top_val[W +: W], last_val[1]);
    repeat (6) @(negedge clk);
    check(top_val[W +: W] == 16'd63, "R9 slot1 after twelve clocks", top_val[W +: W], 63);
    wait_done();

    // R8 outputs hold while idle
    repeat (20) @(negedge clk);
    for (int k = 0; k < K; k++) begin
      check(int'(top_val[k*W +: W]) == last_val[k], "R8 value held", top_val[k*W +: W], last_val[k]);
      check(int'(top_idx[k*IW +: IW]) == last_idx[k], "R8 index held", top_idx[k*IW +: IW], last_idx[k]);
    end

    // R5 all equal
    for (int i = 0; i < N; i++) stim[i] = 16'h1234;
    drive(1'b1);
    wait_done();

    // R4 all zero: removed entries must not win again
    for (int i = 0; i < N; i++) stim[i] = 0;
    drive(1'b1);
    wait_done();

    // R5 duplicated maxima scattered
    rand_stim(1000);
    stim[50] = 5000; stim[7] = 5000; stim[33] = 5000; stim[61] = 4000; stim[3] = 4000;
    drive(1'b1);
    wait_done();

    // R3 extremes at the top index
    for (int i = 0; i < N; i++) stim[i] = 0;
    stim[63] = 65535; stim[0] = 1; stim[62] = 65534;
    drive(1'b1);
    wait_done();

    // R6 ignored starts, R7 earliest restart
    rand_stim(65535);
    drive(1'b1);
    repeat (8) @(negedge clk);
    rand_stim(65535);
    drive(1'b0);
    repeat (20) @(negedge clk);
    rand_stim(65535);
    drive(1'b0);
    rand_stim(65535);
    drive(1'b1);
    wait_done();

    // R7 frames every 32 clocks
    for (int f = 0; f < 4; f++) begin
      rand_stim((f == 2) ? 8 : 65535);
      drive(1'b1);
      repeat (31) @(negedge clk);
    end
    wait_done();

    repeat (40) @(negedge clk);
    check(q_done.size() == 0, "R6 pending frames at end", q_done.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule